// File: doc/BRIEF.md
# Range-to-Bank Association Table

This block sits next to a private L1 cache and answers one question on every miss: which shared L2 bank owns this physical address, and at what network node does that bank live. It holds a small set of entries. Each valid entry covers one contiguous, inclusive address window and names the node of the bank that may cache blocks from that window. An L1 can reach only the banks named in its own table.

A remote controller can rewrite the table while the system runs, for example when banks are handed from one application cluster to another. Rewriting goes through a shadow copy. An edit session starts with a start pulse, which copies the live table into the shadow. Entry writes and an even-split helper then change only the shadow. A commit pulse makes every change live at once. Lookups are refused for the whole session, so no client ever sees a half-built table.

The even-split helper takes a base address, a span and a bank count N. It rewrites the windows of the first N shadow entries so that they tile the span in equal slices, with the remainder added to the last slice. It leaves each entry's node field unchanged, so the controller can load the nodes before or after the split.

Top module: `bank_assoc_table`

## Requirements
- R1: After reset `busy` and `rs_valid` are 0 and every entry is invalid, so any lookup returns a miss.
- R2: A lookup with `lk_req`=1 while `busy`=0 is accepted. One clock later `rs_valid`=1 and `rs_node` holds the node of a valid entry whose window satisfies lo <= address <= hi, both bounds included. `rs_err`=0 in that case.
- R3: When no valid entry matches an accepted lookup, the result has `rs_err`=1 and `rs_node`=0.
- R4: When several valid entries match, the entry with the lowest index wins.
- R5: A `cfg_start` pulse while idle sets `busy` from the next cycle on. While `busy`=1, `lk_req` is not accepted and produces no result.
- R6: An entry write (`cfg_wr` with index, lo, hi, node and valid bit) takes effect only inside an edit session. A write made while `busy`=0 is ignored.
- R7: A `cfg_commit` pulse while busy makes the shadow table live and clears `busy` from the next cycle on. The session starts from a copy of the live table, so entries that were not edited keep their old contents.
- R8: A `cfg_split` pulse during a session with base B, span S and count N (1..ENTRIES) sets shadow entry i < N to lo = B + i*floor(S/N) and hi = lo + floor(S/N) - 1. The exception is entry N-1, whose hi is B + S - 1. Entries N and above become invalid, and every node field is kept.
- R9: A split with count 0 invalidates every entry. A count above ENTRIES is treated as ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Physical address to map |
| rs_valid | output | 1 | Lookup result valid, one cycle after an accepted request |
| rs_node | output | NODE_W | Node address of the owning bank, 0 on a miss |
| rs_err | output | 1 | No valid entry matched |
| busy | output | 1 | Edit session open; lookups refused |
| cfg_start | input | 1 | Open an edit session (copies live table to shadow) |
| cfg_wr | input | 1 | Write one shadow entry |
| cfg_idx | input | IDX_W | Entry index for the write |
| cfg_lo | input | ADDR_W | Lower window bound (inclusive) |
| cfg_hi | input | ADDR_W | Upper window bound (inclusive) |
| cfg_node | input | NODE_W | Bank node address |
| cfg_en | input | 1 | Valid bit written to the entry |
| cfg_split | input | 1 | Apply the even split to the shadow windows |
| split_base | input | ADDR_W | First address of the split span |
| split_span | input | ADDR_W | Number of addresses in the span |
| split_cnt | input | CNT_W | Number of banks to spread the span over |
| cfg_commit | input | 1 | Make the shadow live and close the session |

## Verification
A corrupted window bound shows up as a wrong node or a false miss on the very next lookup that hits the edge of that window. For this reason the bench probes the first and last address of every window, plus the address just outside it. A stuck or early-released busy flag shows up as a result appearing, or going missing, one cycle after a request made during a session. A broken shadow copy or commit path shows up on the first lookup after commit, either as stale nodes on entries that were not edited or as edits that never became visible. A wrong split quotient or remainder rule moves the slice boundaries, and boundary lookups on each slice expose this.

// File: rtl/bat_pkg.sv
package bat_pkg;
  typedef enum logic [0:0] {
    CF_IDLE = 1'b0,
    CF_EDIT = 1'b1
  } cfg_state_e;
endpackage

// File: rtl/bat_split.sv
module bat_split #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5
) (
  input  logic [ADDR_W-1:0]               base,
  input  logic [ADDR_W-1:0]               span,
  input  logic [CNT_W-1:0]                cnt,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  lo,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  hi,
  output logic [ENTRIES-1:0]              vld
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(ENTRIES);

  logic [CNT_W-1:0]  ncl;
  logic [ADDR_W-1:0] slice;
  logic [ADDR_W-1:0] top;

  always_comb begin
    ncl   = (cnt > MAX_CNT) ? MAX_CNT : cnt;
    slice = (ncl == '0) ? '0 : span / ADDR_W'(ncl);
    top   = base + span - ADDR_W'(1);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slice
    always_comb begin
      lo[g]  = base + ADDR_W'(g) * slice;
      vld[g] = CNT_W'(g) < ncl;
      if (CNT_W'(g + 1) == ncl) hi[g] = top;
      else                      hi[g] = base + ADDR_W'(g + 1) * slice - ADDR_W'(1);
    end
  end
endmodule

// File: rtl/bat_match.sv
module bat_match #(
  parameter int ADDR_W  = 32,
  parameter int NODE_W  = 8,
  parameter int ENTRIES = 16
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [ENTRIES-1:0]              vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  lo,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  hi,
  input  logic [ENTRIES-1:0][NODE_W-1:0]  node,
  output logic                            hit,
  output logic [NODE_W-1:0]               hit_node
);
  logic [ENTRIES-1:0] sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign sel[g] = vld[g] && (addr >= lo[g]) && (addr <= hi[g]);
  end

  // Scan from the top down so the lowest matching index is the one kept.
  always_comb begin
    hit      = 1'b0;
    hit_node = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (sel[i]) begin
        hit      = 1'b1;
        hit_node = node[i];
      end
    end
  end
endmodule

// File: rtl/bank_assoc_table.sv
module bank_assoc_table #(
  parameter int ADDR_W  = 32,
  parameter int NODE_W  = 8,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rs_valid,
  output logic [NODE_W-1:0] rs_node,
  output logic              rs_err,
  output logic              busy,
  input  logic              cfg_start,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic              cfg_en,
  input  logic              cfg_split,
  input  logic [ADDR_W-1:0] split_base,
  input  logic [ADDR_W-1:0] split_span,
  input  logic [CNT_W-1:0]  split_cnt,
  input  logic              cfg_commit
);
  import bat_pkg::*;

  cfg_state_e state_q, state_n;

  logic [ENTRIES-1:0]             act_vld_q, shd_vld_q, shd_vld_n;
  logic [ENTRIES-1:0][ADDR_W-1:0] act_lo_q,  shd_lo_q,  shd_lo_n;
  logic [ENTRIES-1:0][ADDR_W-1:0] act_hi_q,  shd_hi_q,  shd_hi_n;
  logic [ENTRIES-1:0][NODE_W-1:0] act_nd_q,  shd_nd_q,  shd_nd_n;

  logic [ENTRIES-1:0][ADDR_W-1:0] sp_lo, sp_hi;
  logic [ENTRIES-1:0]             sp_vld;

  logic              m_hit;
  logic [NODE_W-1:0] m_node;

  logic open_en, commit_en, lk_acc;

  bat_split #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) i_split (
    .base(split_base), .span(split_span), .cnt(split_cnt),
    .lo(sp_lo), .hi(sp_hi), .vld(sp_vld)
  );

  bat_match #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .ENTRIES(ENTRIES)) i_match (
    .addr(lk_addr), .vld(act_vld_q), .lo(act_lo_q), .hi(act_hi_q),
    .node(act_nd_q), .hit(m_hit), .hit_node(m_node)
  );

  assign busy = (state_q == CF_EDIT);

  // Control next state
  always_comb begin
    open_en   = (state_q == CF_IDLE) && cfg_start;
    commit_en = (state_q == CF_EDIT) && cfg_commit;
    lk_acc    = (state_q == CF_IDLE) && lk_req;
    state_n   = state_q;
    if (open_en)   state_n = CF_EDIT;
    if (commit_en) state_n = CF_IDLE;
  end

  // Shadow next state: copy on open, then split, then single-entry write
  always_comb begin
    shd_vld_n = shd_vld_q;
    shd_lo_n  = shd_lo_q;
    shd_hi_n  = shd_hi_q;
    shd_nd_n  = shd_nd_q;
    if (open_en) begin
      shd_vld_n = act_vld_q;
      shd_lo_n  = act_lo_q;
      shd_hi_n  = act_hi_q;
      shd_nd_n  = act_nd_q;
    end else if (state_q == CF_EDIT) begin
      if (cfg_split) begin
        shd_vld_n = sp_vld;
        shd_lo_n  = sp_lo;
        shd_hi_n  = sp_hi;
      end
      if (cfg_wr) begin
        shd_vld_n[cfg_idx] = cfg_en;
        shd_lo_n[cfg_idx]  = cfg_lo;
        shd_hi_n[cfg_idx]  = cfg_hi;
        shd_nd_n[cfg_idx]  = cfg_node;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CF_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_vld_q <= '0;
      shd_lo_q  <= '0;
      shd_hi_q  <= '0;
      shd_nd_q  <= '0;
    end else begin
      shd_vld_q <= shd_vld_n;
      shd_lo_q  <= shd_lo_n;
      shd_hi_q  <= shd_hi_n;
      shd_nd_q  <= shd_nd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld_q <= '0;
      act_lo_q  <= '0;
      act_hi_q  <= '0;
      act_nd_q  <= '0;
    end else if (commit_en) begin
      act_vld_q <= shd_vld_n;
      act_lo_q  <= shd_lo_n;
      act_hi_q  <= shd_hi_n;
      act_nd_q  <= shd_nd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_node  <= '0;
      rs_err   <= 1'b0;
    end else begin
      rs_valid <= lk_acc;
      if (lk_acc) begin
        rs_node <= m_node;
        rs_err  <= !m_hit;
      end
    end
  end
endmodule

// File: rtl/bank_assoc_table_chk.sv
module bank_assoc_table_chk #(
  parameter int NODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic              rs_valid,
  input logic [NODE_W-1:0] rs_node,
  input logic              rs_err,
  input logic              busy,
  input logic              cfg_start,
  input logic              cfg_commit
);
  // R3
  miss_node_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_err) |-> (rs_node == '0));

  // R2
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !busy) |=> rs_valid);

  // R5
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && busy) |=> !rs_valid);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_start));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cfg_commit));
endmodule

bind bank_assoc_table bank_assoc_table_chk #(.NODE_W(NODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .rs_valid(rs_valid),
  .rs_node(rs_node), .rs_err(rs_err), .busy(busy),
  .cfg_start(cfg_start), .cfg_commit(cfg_commit)
);

// File: tb/test_bank_assoc_table.sv
module test_bank_assoc_table;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NW = 8;
  localparam int EN = 16;
  localparam int IW = 4;
  localparam int CW = 5;

  logic clk, rst_n;
  logic lk_req;
  logic [AW-1:0] lk_addr;
  logic rs_valid, rs_err, busy;
  logic [NW-1:0] rs_node;
  logic cfg_start, cfg_wr, cfg_en, cfg_split, cfg_commit;
  logic [IW-1:0] cfg_idx;
  logic [AW-1:0] cfg_lo, cfg_hi, split_base, split_span;
  logic [NW-1:0] cfg_node;
  logic [CW-1:0] split_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [NW-1:0] node;
    logic          err;
    string         tag;
  } exp_t;
  exp_t sb[$];

  bank_assoc_table #(.ADDR_W(AW), .NODE_W(NW), .ENTRIES(EN)) i_bank_assoc_table (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_node(rs_node), .rs_err(rs_err), .busy(busy),
    .cfg_start(cfg_start), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .cfg_node(cfg_node), .cfg_en(cfg_en), .cfg_split(cfg_split),
    .split_base(split_base), .split_span(split_span), .split_cnt(split_cnt),
    .cfg_commit(cfg_commit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && rs_valid) begin
      if (sb.size() == 0) begin
        check("R5 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " node"}, 64'(rs_node), 64'(e.node));
        check({e.tag, " err"},  64'(rs_err),  64'(e.err));
      end
    end
  end

  task automatic lookup(input logic [AW-1:0] a, input logic [NW-1:0] nd,
                        input logic er, input string tag);
    exp_t e;
    e.node = nd; e.err = er; e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic open_edit();
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    check("R5 busy after start", 64'(busy), 1);
  endtask

  task automatic commit();
    @(negedge clk); cfg_commit = 1'b1;
    @(negedge clk); cfg_commit = 1'b0;
    check("R7 busy cleared by commit", 64'(busy), 0);
  endtask

  task automatic wr_entry(input int idx, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                          input logic [NW-1:0] nd, input logic v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = IW'(idx); cfg_lo = lo; cfg_hi = hi; cfg_node = nd; cfg_en = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_split(input logic [AW-1:0] b, input logic [AW-1:0] s, input int n);
    @(negedge clk);
    cfg_split = 1'b1; split_base = b; split_span = s; split_cnt = CW'(n);
    @(negedge clk);
    cfg_split = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    check("watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_addr = '0;
    cfg_start = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0; cfg_split = 1'b0; cfg_commit = 1'b0;
    cfg_idx = '0; cfg_lo = '0; cfg_hi = '0; cfg_node = '0;
    split_base = '0; split_span = '0; split_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy at reset", 64'(busy), 0);
    check("R1 rs_valid at reset", 64'(rs_valid), 0);
    lookup(32'h100, 8'd0, 1'b1, "R1 empty table miss");

    // Program three windows, e2 overlaps e0 and e1
    open_edit();
    wr_entry(0, 32'h1000, 32'h1FFF, 8'd5, 1'b1);
    wr_entry(1, 32'h2000, 32'h2FFF, 8'd9, 1'b1);
    wr_entry(2, 32'h1800, 32'h27FF, 8'd3, 1'b1);
    commit();
    lookup(32'h1000, 8'd5, 1'b0, "R2 low bound e0");
    lookup(32'h1FFF, 8'd5, 1'b0, "R2 high bound e0");
    lookup(32'h2000, 8'd9, 1'b0, "R2 low bound e1");
    lookup(32'h2FFF, 8'd9, 1'b0, "R2 high bound e1");
    lookup(32'h3000, 8'd0, 1'b1, "R3 above all");
    lookup(32'h0FFF, 8'd0, 1'b1, "R3 below all");
    lookup(32'h1900, 8'd5, 1'b0, "R4 overlap e0 e2");
    lookup(32'h2100, 8'd9, 1'b0, "R4 overlap e1 e2");

    // R6 write while idle is ignored
    wr_entry(3, 32'h5000, 32'h5FFF, 8'd7, 1'b1);
    lookup(32'h5000, 8'd0, 1'b1, "R6 idle write ignored");

    // R5 lookup refused while busy; R7 commit and retention
    open_edit();
    @(negedge clk); lk_req = 1'b1; lk_addr = 32'h1000;
    @(negedge clk); lk_req = 1'b0;
    check("R5 no result while busy", 64'(rs_valid), 0);
    wr_entry(0, 32'h1000, 32'h1FFF, 8'd11, 1'b1);
    commit();
    lookup(32'h1000, 8'd11, 1'b0, "R7 edited entry live");
    lookup(32'h2000, 8'd9, 1'b0, "R7 unedited entry kept");

    // R8 even split, span 0x1003 over 3 banks: slice 0x556, remainder to last
    open_edit();
    do_split(32'h10000, 32'h1003, 3);
    commit();
    lookup(32'h10000, 8'd11, 1'b0, "R8 slice0 low");
    lookup(32'h10555, 8'd11, 1'b0, "R8 slice0 high");
    lookup(32'h10556, 8'd9, 1'b0, "R8 slice1 low");
    lookup(32'h10AAB, 8'd9, 1'b0, "R8 slice1 high");
    lookup(32'h10AAC, 8'd3, 1'b0, "R8 slice2 low");
    lookup(32'h11002, 8'd3, 1'b0, "R8 last slice remainder");
    lookup(32'h11003, 8'd0, 1'b1, "R8 past span");
    lookup(32'h1000, 8'd0, 1'b1, "R8 old window gone");

    // R9 count 0 invalidates everything
    open_edit();
    do_split(32'h10000, 32'h1003, 0);
    commit();
    lookup(32'h10000, 8'd0, 1'b1, "R9 count zero");

    // R9 count above ENTRIES clamps to 16 slices of 0x10
    open_edit();
    wr_entry(15, 32'h0, 32'h0, 8'd4, 1'b1);
    do_split(32'h0, 32'h100, 20);
    commit();
    lookup(32'h0F, 8'd11, 1'b0, "R9 clamp slice0");
    lookup(32'hF0, 8'd4, 1'b0, "R9 clamp slice15 low");
    lookup(32'hFF, 8'd4, 1'b0, "R9 clamp slice15 high");
    lookup(32'h100, 8'd0, 1'b1, "R9 clamp past span");

    repeat (4) @(negedge clk);
    check("scoreboard drained", 64'(sb.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule